// File: doc/BRIEF.md
# Next-PC Instruction Fetch Sequencer

This block owns the program counter of a single-cycle processor and works out, every clock, which instruction comes next. The counter is kept as a word address (the byte address without its two always-zero low bits), and the byte address presented to instruction memory is that word address with two zero bits appended. On each rising clock edge the counter advances along one of three paths. The sequential path steps to the next word. The branch path adds a sign-extended 16-bit word offset to the sequential address. The jump path keeps the top address bits of the sequential address and replaces the rest with a 26-bit word target.

The decoder supplies a branch enable and a jump enable. The ALU supplies its zero flag, which decides whether an enabled branch is taken. The current instruction supplies the 16-bit offset and the 26-bit target fields. Jump wins when both enables are high. A synchronous active-low reset loads a parameterised start word address, which defaults to zero. All address arithmetic wraps around the top of the address space.

Top module: `fetch_pc_sequencer`

## Requirements
- R1: A rising clock edge with `rst_n` low loads the word address `RESET_WORD`, so `imem_addr` becomes `RESET_WORD` shifted left by 2 (0x00000000 by default). Reset overrides every other input.
- R2: Bits [1:0] of `imem_addr` are always 0 once reset has been applied.
- R3: With `br_en`=0 and `jmp_en`=0, each rising edge adds 4 to `imem_addr`.
- R4: With `br_en`=1, `alu_zero`=1 and `jmp_en`=0, the next `imem_addr` is the current `imem_addr` + 4 + (sign-extended `imm_ofs` × 4). Bit 15 of `imm_ofs` is the sign bit.
- R5: With `br_en`=1, `alu_zero`=0 and `jmp_en`=0, the next `imem_addr` is the current `imem_addr` + 4. The offset has no effect.
- R6: With `jmp_en`=1, the next `imem_addr` is {bits [31:28] of (current `imem_addr` + 4), `jmp_tgt`[25:0], 2'b00}, whatever the values of `br_en`, `alu_zero` and `imm_ofs`.
- R7: Address arithmetic wraps modulo 2^32 bytes (2^30 words). A step past 0xFFFFFFFC gives 0x00000000, and a negative branch below 0 wraps to the top of the space.
- R8: `alu_zero` has no effect while `br_en` is 0.
- R9: The upper four jump bits come from the incremented address. A jump from byte address 0x0FFFFFFC lands in the 0x1xxxxxxx region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| br_en | input | 1 | Current instruction is a conditional branch |
| jmp_en | input | 1 | Current instruction is an absolute jump |
| alu_zero | input | 1 | ALU zero flag; an enabled branch is taken when it is 1 |
| imm_ofs | input | 16 | Signed branch offset in words |
| jmp_tgt | input | 26 | Word target field of a jump |
| imem_addr | output | 32 | Byte address of the current instruction |

## Verification
The bench aims at the address edges. It steps off 0xFFFFFFFC and branches backwards from 0. A design that used the wrong width or dropped the carry would land on a nonzero or misaligned address there. It jumps from 0x0FFFFFFC, where the upper four bits of the current address and of the incremented address differ. A design that took those bits from the unincremented counter would stay in region 0 instead of moving to 0x1xxxxxxx. It also drives jump together with a taken branch, drives a set zero flag with the branch disabled, and asserts reset together with a jump. Each of these exposes a wrong priority or a leaking condition as an address that differs from the sequential or jump value.

// File: rtl/fetch_pc_pkg.sv
// Shared types for the fetch sequencer.
// Assumes: nothing beyond the encoding below, which only this block decodes.
package fetch_pc_pkg;

    // Which candidate address the counter loads on the next edge.
    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_BRANCH = 2'd1,
        NPC_JUMP   = 2'd2
    } npc_src_e;

endpackage

// File: rtl/npc_select.sv
// Picks the next-address source from the control bits.
// Assumes: jump outranks branch; a branch is taken only when the zero flag is set.
module npc_select
    import fetch_pc_pkg::*;
(
    input  logic     br_en,
    input  logic     jmp_en,
    input  logic     alu_zero,
    output npc_src_e src
);

    // Priority decode: jump, then taken branch, then sequential.
    always_comb begin
        if (jmp_en)
            src = NPC_JUMP;
        else if (br_en && alu_zero)
            src = NPC_BRANCH;
        else
            src = NPC_SEQ;
    end

endmodule

// File: rtl/npc_targets.sv
// Computes the three candidate word addresses from the current counter.
// Assumes: TGT_W < WORD_W; the jump keeps the upper bits of the incremented
// address; all sums wrap modulo 2^WORD_W.
module npc_targets #(
    parameter int WORD_W = 30,
    parameter int OFS_W  = 16,
    parameter int TGT_W  = 26
) (
    input  logic [WORD_W-1:0] pc_word,
    input  logic [OFS_W-1:0]  imm_ofs,
    input  logic [TGT_W-1:0]  jmp_tgt,
    output logic [WORD_W-1:0] seq_word,
    output logic [WORD_W-1:0] br_word,
    output logic [WORD_W-1:0] jmp_word
);

    localparam int UPPER_W = WORD_W - TGT_W;

    logic [WORD_W-1:0] ofs_ext;

    // Sign-extend the offset, or truncate it when it is wider than the counter.
    generate
        if (OFS_W < WORD_W) begin : g_ofs_ext
            assign ofs_ext = {{(WORD_W-OFS_W){imm_ofs[OFS_W-1]}}, imm_ofs};
        end else begin : g_ofs_trunc
            assign ofs_ext = imm_ofs[WORD_W-1:0];
        end
    endgenerate

    // Sequential step and branch sum, both wrapping.
    always_comb begin
        seq_word = pc_word + WORD_W'(1);
        br_word  = seq_word + ofs_ext;
    end

    // Jump splices the target under the upper bits of the incremented address.
    generate
        if (UPPER_W > 0) begin : g_jmp_splice
            assign jmp_word = {seq_word[WORD_W-1:TGT_W], jmp_tgt};
        end else begin : g_jmp_full
            assign jmp_word = jmp_tgt[WORD_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/pc_reg.sv
// Word-address program counter with a source mux in front of it.
// Assumes: synchronous active-low reset; the counter updates on the same
// rising edge as the rest of the datapath state.
module pc_reg
    import fetch_pc_pkg::*;
#(
    parameter int                  WORD_W     = 30,
    parameter logic [WORD_W-1:0]   RESET_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  npc_src_e          src,
    input  logic [WORD_W-1:0] seq_word,
    input  logic [WORD_W-1:0] br_word,
    input  logic [WORD_W-1:0] jmp_word,
    output logic [WORD_W-1:0] pc_q
);

    logic [WORD_W-1:0] pc_d;

    // Select the candidate named by the decoded source.
    always_comb begin
        case (src)
            NPC_BRANCH: pc_d = br_word;
            NPC_JUMP:   pc_d = jmp_word;
            default:    pc_d = seq_word;
        endcase
    end

    // Counter register with synchronous reset to the start address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= RESET_WORD;
        else
            pc_q <= pc_d;
    end

endmodule

// File: rtl/fetch_pc_sequencer.sv
// Top of the fetch sequencer: holds the word-address counter and presents
// the byte address to instruction memory.
// Assumes: control bits and instruction fields are valid for the instruction
// now at imem_addr; ADDR_W - 2 > TGT_W.
module fetch_pc_sequencer
    import fetch_pc_pkg::*;
#(
    parameter int                  ADDR_W     = 32,
    parameter int                  OFS_W      = 16,
    parameter int                  TGT_W      = 26,
    parameter logic [ADDR_W-3:0]   RESET_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_en,
    input  logic              jmp_en,
    input  logic              alu_zero,
    input  logic [OFS_W-1:0]  imm_ofs,
    input  logic [TGT_W-1:0]  jmp_tgt,
    output logic [ADDR_W-1:0] imem_addr
);

    localparam int WORD_W = ADDR_W - 2;

    npc_src_e          src;
    logic [WORD_W-1:0] pc_word;
    logic [WORD_W-1:0] seq_word;
    logic [WORD_W-1:0] br_word;
    logic [WORD_W-1:0] jmp_word;

    npc_select u_select (
        .br_en    (br_en),
        .jmp_en   (jmp_en),
        .alu_zero (alu_zero),
        .src      (src)
    );

    npc_targets #(
        .WORD_W (WORD_W),
        .OFS_W  (OFS_W),
        .TGT_W  (TGT_W)
    ) u_targets (
        .pc_word  (pc_word),
        .imm_ofs  (imm_ofs),
        .jmp_tgt  (jmp_tgt),
        .seq_word (seq_word),
        .br_word  (br_word),
        .jmp_word (jmp_word)
    );

    pc_reg #(
        .WORD_W     (WORD_W),
        .RESET_WORD (RESET_WORD)
    ) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .seq_word (seq_word),
        .br_word  (br_word),
        .jmp_word (jmp_word),
        .pc_q     (pc_q_unused_guard)
    );

    logic [WORD_W-1:0] pc_q_unused_guard;

    // Byte address: word address with the two alignment bits appended.
    always_comb begin
        pc_word   = pc_q_unused_guard;
        imem_addr = {pc_word, 2'b00};
    end

endmodule

// File: rtl/fetch_pc_checker.sv
// Port-level properties of the fetch sequencer, bound to its top.
// Assumes: reset is applied from time zero.
module fetch_pc_checker #(
    parameter int                  ADDR_W     = 32,
    parameter int                  OFS_W      = 16,
    parameter int                  TGT_W      = 26,
    parameter logic [ADDR_W-3:0]   RESET_WORD = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              br_en,
    input logic              jmp_en,
    input logic              alu_zero,
    input logic [OFS_W-1:0]  imm_ofs,
    input logic [TGT_W-1:0]  jmp_tgt,
    input logic [ADDR_W-1:0] imem_addr
);

    localparam int PAD_W = ADDR_W - OFS_W - 2;

    logic [ADDR_W-1:0] step_bytes;
    logic [ADDR_W-1:0] ofs_bytes;

    // Byte-domain reference quantities taken from the ports.
    always_comb begin
        step_bytes = imem_addr + ADDR_W'(4);
        ofs_bytes  = {{PAD_W{imm_ofs[OFS_W-1]}}, imm_ofs, 2'b00};
    end

    // R1: a reset edge loads the start address
    assert_reset_load_R1: assert property (@(posedge clk)
        !rst_n |=> imem_addr == {RESET_WORD, 2'b00});

    // R2: alignment bits stay clear
    assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        imem_addr[1:0] == 2'b00);

    // R3 and R8: no branch, no jump gives a plain step, zero flag ignored
    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_en && !jmp_en) |=> imem_addr == $past(step_bytes));

    // R4: taken branch adds the scaled offset to the stepped address
    assert_branch_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && alu_zero && !jmp_en) |=>
            imem_addr == $past(step_bytes) + $past(ofs_bytes));

    // R5: untaken branch steps
    assert_branch_untaken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && !alu_zero && !jmp_en) |=> imem_addr == $past(step_bytes));

    // R6 and R9: jump target field and upper bits of the stepped address
    assert_jump_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_en |=> (imem_addr[TGT_W+1:2] == $past(jmp_tgt)) &&
                   (imem_addr[ADDR_W-1:TGT_W+2] == $past(step_bytes[ADDR_W-1:TGT_W+2])));

endmodule

bind fetch_pc_sequencer fetch_pc_checker #(
    .ADDR_W     (ADDR_W),
    .OFS_W      (OFS_W),
    .TGT_W      (TGT_W),
    .RESET_WORD (RESET_WORD)
) u_fetch_pc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_en     (br_en),
    .jmp_en    (jmp_en),
    .alu_zero  (alu_zero),
    .imm_ofs   (imm_ofs),
    .jmp_tgt   (jmp_tgt),
    .imem_addr (imem_addr)
);

// File: tb/fetch_pc_sequencer_bench.sv
// Directed bench for the fetch sequencer: one task per scenario.
module fetch_pc_sequencer_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_en = 1'b0;
    logic        jmp_en = 1'b0;
    logic        alu_zero = 1'b0;
    logic [15:0] imm_ofs = '0;
    logic [25:0] jmp_tgt = '0;
    logic [31:0] imem_addr;

    int n_checks = 0;
    int n_bad = 0;

    fetch_pc_sequencer u_fetch_pc_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .br_en     (br_en),
        .jmp_en    (jmp_en),
        .alu_zero  (alu_zero),
        .imm_ofs   (imm_ofs),
        .jmp_tgt   (jmp_tgt),
        .imem_addr (imem_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Applies one cycle of controls, waits past the edge, checks the given address.
    task automatic cycle(input string req, input logic b, input logic j, input logic z,
                         input logic [15:0] imm, input logic [25:0] tgt,
                         input logic [31:0] exp);
        br_en = b; jmp_en = j; alu_zero = z; imm_ofs = imm; jmp_tgt = tgt;
        @(posedge clk);
        #1;
        check(req, imem_addr, exp);
        check("R2", {30'd0, imem_addr[1:0]}, 32'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        // R1: reset wins over an asserted jump
        cycle("R1", 1'b1, 1'b1, 1'b1, 16'h0005, 26'h0ABCDEF, 32'h0000_0000);
        rst_n = 1'b1;
    endtask

    task automatic t_sequential;
        cycle("R3", 1'b0, 1'b0, 1'b0, 16'h1234, 26'h0, 32'h0000_0004);
        cycle("R3", 1'b0, 1'b0, 1'b0, 16'h0, 26'h3FF_FFFF, 32'h0000_0008);
        cycle("R3", 1'b0, 1'b0, 1'b0, 16'hFFFF, 26'h0, 32'h0000_000C);
    endtask

    task automatic t_zero_ignored;
        // R8: zero flag set, branch disabled, large offset present
        cycle("R8", 1'b0, 1'b0, 1'b1, 16'h7FFF, 26'h0, 32'h0000_0010);
        cycle("R8", 1'b0, 1'b0, 1'b1, 16'h8000, 26'h0, 32'h0000_0014);
    endtask

    task automatic t_branch;
        // R4: 0x14 + 4 + 3*4 = 0x24
        cycle("R4", 1'b1, 1'b0, 1'b1, 16'h0003, 26'h0, 32'h0000_0024);
        // R4: 0x24 + 4 - 2*4 = 0x20
        cycle("R4", 1'b1, 1'b0, 1'b1, 16'hFFFE, 26'h0, 32'h0000_0020);
        // R4: offset -1 lands on itself: 0x20 + 4 - 4
        cycle("R4", 1'b1, 1'b0, 1'b1, 16'hFFFF, 26'h0, 32'h0000_0020);
        // R5: not taken, offset ignored
        cycle("R5", 1'b1, 1'b0, 1'b0, 16'h0100, 26'h0, 32'h0000_0024);
        cycle("R5", 1'b1, 1'b0, 1'b0, 16'h8000, 26'h0, 32'h0000_0028);
    endtask

    task automatic t_jump;
        // R6: plain jump in region 0
        cycle("R6", 1'b0, 1'b1, 1'b0, 16'h0, 26'h0000100, 32'h0000_0400);
        // R6: jump outranks a taken branch
        cycle("R6", 1'b1, 1'b1, 1'b1, 16'h0040, 26'h0000010, 32'h0000_0040);
    endtask

    task automatic t_jump_upper;
        // R6: reach the last word of region 0
        cycle("R6", 1'b0, 1'b1, 1'b0, 16'h0, 26'h3FF_FFFF, 32'h0FFF_FFFC);
        // R9: upper bits taken from 0x10000000, not from 0x0FFFFFFC
        cycle("R9", 1'b0, 1'b1, 1'b0, 16'h0, 26'h0000005, 32'h1000_0014);
        // R9: stays in region 1 on a further jump
        cycle("R9", 1'b0, 1'b1, 1'b0, 16'h0, 26'h0000000, 32'h1000_0000);
    endtask

    task automatic t_wrap;
        rst_n = 1'b0;
        cycle("R1", 1'b0, 1'b0, 1'b0, 16'h0, 26'h0, 32'h0000_0000);
        rst_n = 1'b1;
        // R7: 0 + 4 - 8 wraps to the top word
        cycle("R7", 1'b1, 1'b0, 1'b1, 16'hFFFE, 26'h0, 32'hFFFF_FFFC);
        // R7: step off the top wraps to 0
        cycle("R7", 1'b0, 1'b0, 1'b0, 16'h0, 26'h0, 32'h0000_0000);
        // R7: jump from the top word: upper bits of 0x00000000
        cycle("R7", 1'b1, 1'b0, 1'b1, 16'hFFFE, 26'h0, 32'hFFFF_FFFC);
        cycle("R7", 1'b0, 1'b1, 1'b0, 16'h0, 26'h0000002, 32'h0000_0008);
    endtask

    task automatic t_reset_midrun;
        cycle("R3", 1'b0, 1'b0, 1'b0, 16'h0, 26'h0, 32'h0000_000C);
        rst_n = 1'b0;
        cycle("R1", 1'b1, 1'b0, 1'b1, 16'h0010, 26'h0, 32'h0000_0000);
        rst_n = 1'b1;
        cycle("R3", 1'b0, 1'b0, 1'b0, 16'h0, 26'h0, 32'h0000_0004);
    endtask

    initial begin
        #1;
        t_reset();
        t_sequential();
        t_zero_ignored();
        t_branch();
        t_jump();
        t_jump_upper();
        t_wrap();
        t_reset_midrun();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule